// File: doc/BRIEF.md
# Touch Pointer Report Builder

This block turns the raw bytes of one touch-sensor sample into a pointer report. In relative mode it reads three bytes and produces signed X and Y motion plus a tap button. In absolute mode it reads four bytes and produces a 12-bit X position, a 12-bit Y position and a 6-bit pressure value. Absolute positions can be limited to a configured active window, and window-limited positions can then be rescaled to a configured output resolution.

Packets enter through a valid/ready byte interface, one sample per transfer. Reports leave through a valid/ready interface. The configuration inputs are static while a sample is in flight. Only one sample is processed at a time, and every sample takes the same number of cycles whatever the mode, so reports always leave in arrival order. The configuration must keep the low bound of each window below its high bound and each resolution nonzero.

Top module: `touch_report_path`

## Requirements
- R1: In relative mode, X motion is byte 1 when bit 4 of byte 0 is 0 and byte 1 minus 256 when that bit is 1. Y motion is formed the same way from byte 2 and bit 5 of byte 0. Both are sign-extended to COORD_W bits. Byte k of a packet sits on pkt_data[8k+7:8k].
- R2: In relative mode, rpt_btn equals bit 0 of byte 0 when cfg_tap_en is 1 and is 0 otherwise. rpt_z is 0 and byte 3 is ignored.
- R3: In absolute mode, X is {byte2[3:0], byte0}, Y is {byte2[7:4], byte1} and Z is byte3[5:0]. rpt_btn is 0.
- R4: An absolute sample whose X, Y and Z are all zero is reported as all zeros, even when window limiting and rescaling are enabled.
- R5: With cfg_clip_en set, a non-idle absolute X is raised to cfg_x_lo if below it and lowered to cfg_x_hi if above it. Y is treated the same way against cfg_y_lo and cfg_y_hi.
- R6: With cfg_clip_en and cfg_scale_en both set, each axis of a non-idle absolute sample is reported as (limited value − lo) × res / (hi − lo), truncated, using a 2×COORD_W-bit product.
- R7: cfg_scale_en has no effect on a report when cfg_clip_en is 0.
- R8: pkt_ready is 0 from the accepting edge until the report is taken. The cycles from accept to rpt_valid are the same for every mode and option.
- R9: While rpt_valid is 1 and rpt_ready is 0, all report outputs stay unchanged.
- R10: After reset, rpt_valid is 0 and pkt_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rel_mode | input | 1 | 1 = relative packets, 0 = absolute packets |
| cfg_tap_en | input | 1 | Report the tap button in relative mode |
| cfg_clip_en | input | 1 | Limit absolute positions to the window |
| cfg_scale_en | input | 1 | Rescale limited positions |
| cfg_x_lo | input | COORD_W | Window low bound, X |
| cfg_x_hi | input | COORD_W | Window high bound, X |
| cfg_y_lo | input | COORD_W | Window low bound, Y |
| cfg_y_hi | input | COORD_W | Window high bound, Y |
| cfg_x_res | input | COORD_W | Output resolution, X |
| cfg_y_res | input | COORD_W | Output resolution, Y |
| pkt_valid | input | 1 | Packet present |
| pkt_ready | output | 1 | Block can accept a packet |
| pkt_data | input | PKT_BYTES*8 | Packet bytes, byte 0 in the low bits |
| rpt_valid | output | 1 | Report present |
| rpt_ready | input | 1 | Consumer takes the report |
| rpt_x | output | COORD_W | X motion or position |
| rpt_y | output | COORD_W | Y motion or position |
| rpt_z | output | 6 | Pressure (absolute mode) |
| rpt_btn | output | 1 | Tap button (relative mode) |

## Verification
Relative packets are tried with each sign bit set and clear, including the extreme of −256, and with tap reporting on and off to separate the two sign bits and show the button gating. Absolute packets with distinct nibbles in the shared byte tell the X and Y nibble placement apart, while packets below, inside and above the window, an all-zero packet and a packet with only pressure nonzero separate window limiting from the idle bypass. Rescaling is tried with and without window limiting enabled, and a long run of mixed random packets under random consumer stalls compares every report and its latency against a model in arrival order.

// File: rtl/touch_pkg.sv
package touch_pkg;
  localparam int BYTE_W = 8;
  localparam int Z_W    = 6;
  localparam int NAXES  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLAMP = 2'd1,
    ST_DIV   = 2'd2,
    ST_OUT   = 2'd3
  } tpd_state_t;
endpackage

// File: rtl/tpd_unpack.sv
module tpd_unpack
  import touch_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic               rel_mode,
  input  logic               tap_en,
  input  logic [BYTE_W-1:0]  b0,
  input  logic [BYTE_W-1:0]  b1,
  input  logic [BYTE_W-1:0]  b2,
  input  logic [Z_W-1:0]     b3_low,
  output logic [COORD_W-1:0] x,
  output logic [COORD_W-1:0] y,
  output logic [Z_W-1:0]     z,
  output logic               btn,
  output logic               idle
);
  localparam int REL_W  = BYTE_W + 1;
  localparam int ABS_W  = BYTE_W + 4;

  logic [REL_W-1:0] rel_x, rel_y;
  logic [ABS_W-1:0] abs_x, abs_y;

  always_comb begin
    rel_x = {b0[4], b1};
    rel_y = {b0[5], b2};
    abs_x = {b2[3:0], b0};
    abs_y = {b2[7:4], b1};
    if (rel_mode) begin
      x    = {{(COORD_W-REL_W){rel_x[REL_W-1]}}, rel_x};
      y    = {{(COORD_W-REL_W){rel_y[REL_W-1]}}, rel_y};
      z    = '0;
      btn  = tap_en & b0[0];
      idle = 1'b0;
    end else begin
      x    = {{(COORD_W-ABS_W){1'b0}}, abs_x};
      y    = {{(COORD_W-ABS_W){1'b0}}, abs_y};
      z    = b3_low;
      btn  = 1'b0;
      idle = (abs_x == '0) && (abs_y == '0) && (b3_low == '0);
    end
  end
endmodule

// File: rtl/tpd_window.sv
module tpd_window #(
  parameter int COORD_W = 16
) (
  input  logic               en,
  input  logic [COORD_W-1:0] val,
  input  logic [COORD_W-1:0] lo,
  input  logic [COORD_W-1:0] hi,
  output logic [COORD_W-1:0] lim
);
  always_comb begin
    if (!en)          lim = val;
    else if (val < lo) lim = lo;
    else if (val > hi) lim = hi;
    else              lim = val;
  end

  always_comb begin
    if (en && (lo < hi)) begin
      assert_window_range_R5: assert ((lim >= lo) && (lim <= hi));
    end
  end
endmodule

// File: rtl/tpd_divider.sv
module tpd_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [W:0]       shifted;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      rem_q <= fits ? diff : shifted;
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign quotient = quo_q;

  logic [W-1:0]   sav_n;
  logic [2*W-1:0] prod_chk;
  always_ff @(posedge clk) begin
    if (rst)        sav_n <= '0;
    else if (start) sav_n <= dividend;
  end
  assign prod_chk = {{W{1'b0}}, quo_q} * {{W{1'b0}}, dvs_q};

  assert_div_result_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_q) && (dvs_q != '0)) |->
      ((prod_chk <= {{W{1'b0}}, sav_n}) &&
       (({{W{1'b0}}, sav_n} - prod_chk) < {{W{1'b0}}, dvs_q})));

  assert_div_starts_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);
endmodule

// File: rtl/touch_report_path.sv
module touch_report_path
  import touch_pkg::*;
#(
  parameter int COORD_W   = 16,
  parameter int PKT_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_rel_mode,
  input  logic                        cfg_tap_en,
  input  logic                        cfg_clip_en,
  input  logic                        cfg_scale_en,
  input  logic [COORD_W-1:0]          cfg_x_lo,
  input  logic [COORD_W-1:0]          cfg_x_hi,
  input  logic [COORD_W-1:0]          cfg_y_lo,
  input  logic [COORD_W-1:0]          cfg_y_hi,
  input  logic [COORD_W-1:0]          cfg_x_res,
  input  logic [COORD_W-1:0]          cfg_y_res,
  input  logic                        pkt_valid,
  output logic                        pkt_ready,
  input  logic [PKT_BYTES*BYTE_W-1:0] pkt_data,
  output logic                        rpt_valid,
  input  logic                        rpt_ready,
  output logic [COORD_W-1:0]          rpt_x,
  output logic [COORD_W-1:0]          rpt_y,
  output logic [Z_W-1:0]              rpt_z,
  output logic                        rpt_btn
);
  localparam int PROD_W = 2 * COORD_W;

  tpd_state_t state_q;

  logic [COORD_W-1:0] un_x, un_y;
  logic [Z_W-1:0]     un_z;
  logic               un_btn, un_idle;

  logic [COORD_W-1:0] dec_q   [NAXES];
  logic [Z_W-1:0]     dec_z_q;
  logic               dec_btn_q, dec_idle_q, dec_rel_q;
  logic [COORD_W-1:0] lim_q   [NAXES];
  logic               scale_q;
  logic               rdy_q, vld_q;
  logic [COORD_W-1:0] out_q   [NAXES];
  logic [Z_W-1:0]     out_z_q;
  logic               out_btn_q;

  logic               win_en, start;
  logic [COORD_W-1:0] ax_lo   [NAXES];
  logic [COORD_W-1:0] ax_hi   [NAXES];
  logic [COORD_W-1:0] ax_res  [NAXES];
  logic [COORD_W-1:0] lim     [NAXES];
  logic [NAXES-1:0]   busy;
  logic [PROD_W-1:0]  quo     [NAXES];

  assign ax_lo[0]  = cfg_x_lo;
  assign ax_lo[1]  = cfg_y_lo;
  assign ax_hi[0]  = cfg_x_hi;
  assign ax_hi[1]  = cfg_y_hi;
  assign ax_res[0] = cfg_x_res;
  assign ax_res[1] = cfg_y_res;

  tpd_unpack #(.COORD_W(COORD_W)) u_unpack (
    .rel_mode (cfg_rel_mode),
    .tap_en   (cfg_tap_en),
    .b0       (pkt_data[0*BYTE_W +: BYTE_W]),
    .b1       (pkt_data[1*BYTE_W +: BYTE_W]),
    .b2       (pkt_data[2*BYTE_W +: BYTE_W]),
    .b3_low   (pkt_data[3*BYTE_W +: Z_W]),
    .x        (un_x),
    .y        (un_y),
    .z        (un_z),
    .btn      (un_btn),
    .idle     (un_idle)
  );

  assign win_en = cfg_clip_en && !dec_rel_q && !dec_idle_q;
  assign start  = (state_q == ST_CLAMP);

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    logic [COORD_W-1:0] offs;
    logic [PROD_W-1:0]  num;
    logic [PROD_W-1:0]  den;

    tpd_window #(.COORD_W(COORD_W)) u_window (
      .en  (win_en),
      .val (dec_q[a]),
      .lo  (ax_lo[a]),
      .hi  (ax_hi[a]),
      .lim (lim[a])
    );

    assign offs = lim[a] - ax_lo[a];
    assign num  = PROD_W'(offs) * PROD_W'(ax_res[a]);
    assign den  = PROD_W'(ax_hi[a] - ax_lo[a]);

    tpd_divider #(.W(PROD_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .dividend (num),
      .divisor  (den),
      .busy     (busy[a]),
      .quotient (quo[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rdy_q      <= 1'b1;
      vld_q      <= 1'b0;
      dec_z_q    <= '0;
      dec_btn_q  <= 1'b0;
      dec_idle_q <= 1'b0;
      dec_rel_q  <= 1'b0;
      scale_q    <= 1'b0;
      out_z_q    <= '0;
      out_btn_q  <= 1'b0;
      for (int a = 0; a < NAXES; a++) begin
        dec_q[a] <= '0;
        lim_q[a] <= '0;
        out_q[a] <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pkt_valid) begin
            dec_q[0]   <= un_x;
            dec_q[1]   <= un_y;
            dec_z_q    <= un_z;
            dec_btn_q  <= un_btn;
            dec_idle_q <= un_idle;
            dec_rel_q  <= cfg_rel_mode;
            rdy_q      <= 1'b0;
            state_q    <= ST_CLAMP;
          end
        end
        ST_CLAMP: begin
          for (int a = 0; a < NAXES; a++) lim_q[a] <= lim[a];
          scale_q <= win_en && cfg_scale_en;
          state_q <= ST_DIV;
        end
        ST_DIV: begin
          if (busy == '0) begin
            for (int a = 0; a < NAXES; a++)
              out_q[a] <= scale_q ? quo[a][COORD_W-1:0] : lim_q[a];
            out_z_q   <= dec_z_q;
            out_btn_q <= dec_btn_q;
            vld_q     <= 1'b1;
            state_q   <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (rpt_ready) begin
            vld_q   <= 1'b0;
            rdy_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pkt_ready = rdy_q;
  assign rpt_valid = vld_q;
  assign rpt_x     = out_q[0];
  assign rpt_y     = out_q[1];
  assign rpt_z     = out_z_q;
  assign rpt_btn   = out_btn_q;

  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
    rpt_valid |-> !pkt_ready);

  assert_report_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !rpt_ready) |=>
      (rpt_valid && $stable(rpt_x) && $stable(rpt_y) && $stable(rpt_z) && $stable(rpt_btn)));

  assert_btn_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && dec_rel_q && !cfg_tap_en) |-> (!rpt_btn && (rpt_z == '0)));

  assert_scale_bound_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(rpt_valid) && scale_q) |-> ((rpt_x <= cfg_x_res) && (rpt_y <= cfg_y_res)));

  assert_abs_no_btn_R3: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && !dec_rel_q) |-> !rpt_btn);
endmodule

// File: tb/sim_touch_report_path.sv
module sim_touch_report_path;
  localparam int CW = 16;

  typedef struct {
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic [5:0]    z;
    logic          btn;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_rel_mode = 1'b0, cfg_tap_en = 1'b0, cfg_clip_en = 1'b0, cfg_scale_en = 1'b0;
  logic [CW-1:0] cfg_x_lo = 16'd100, cfg_x_hi = 16'd1900, cfg_y_lo = 16'd200, cfg_y_hi = 16'd1400;
  logic [CW-1:0] cfg_x_res = 16'd1024, cfg_y_res = 16'd1024;
  logic          pkt_valid = 1'b0;
  logic          pkt_ready;
  logic [31:0]   pkt_data = '0;
  logic          rpt_valid;
  logic          rpt_ready = 1'b0;
  logic [CW-1:0] rpt_x, rpt_y;
  logic [5:0]    rpt_z;
  logic          rpt_btn;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   acc_cyc = 0;
  int   ref_lat = -1;
  bit   done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  touch_report_path #(.COORD_W(CW), .PKT_BYTES(4)) u0 (
    .clk(clk), .rst(rst),
    .cfg_rel_mode(cfg_rel_mode), .cfg_tap_en(cfg_tap_en),
    .cfg_clip_en(cfg_clip_en), .cfg_scale_en(cfg_scale_en),
    .cfg_x_lo(cfg_x_lo), .cfg_x_hi(cfg_x_hi), .cfg_y_lo(cfg_y_lo), .cfg_y_hi(cfg_y_hi),
    .cfg_x_res(cfg_x_res), .cfg_y_res(cfg_y_res),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_x(rpt_x), .rpt_y(rpt_y), .rpt_z(rpt_z), .rpt_btn(rpt_btn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input bit rel, tap, clip, scale,
                                 input logic [7:0] b0, b1, b2, b3);
    exp_t   e;
    longint x, y, z;
    if (rel) begin
      // R1: sign bit 4 / 5 of byte 0 selects byte minus 256
      x = b0[4] ? longint'(b1) - 256 : longint'(b1);
      y = b0[5] ? longint'(b2) - 256 : longint'(b2);
      e.x = CW'(x);
      e.y = CW'(y);
      e.z = 6'd0;
      e.btn = tap & b0[0];
    end else begin
      x = longint'({b2[3:0], b0});
      y = longint'({b2[7:4], b1});
      z = longint'(b3[5:0]);
      if (clip && !(x == 0 && y == 0 && z == 0)) begin
        if (x < cfg_x_lo) x = cfg_x_lo;
        if (x > cfg_x_hi) x = cfg_x_hi;
        if (y < cfg_y_lo) y = cfg_y_lo;
        if (y > cfg_y_hi) y = cfg_y_hi;
        if (scale) begin
          x = (x - cfg_x_lo) * cfg_x_res / (cfg_x_hi - cfg_x_lo);
          y = (y - cfg_y_lo) * cfg_y_res / (cfg_y_hi - cfg_y_lo);
        end
      end
      e.x = CW'(x);
      e.y = CW'(y);
      e.z = 6'(z);
      e.btn = 1'b0;
    end
    return e;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
  endtask

  task automatic set_win(input logic [CW-1:0] xl, xh, yl, yh, xr, yr);
    wait_idle();
    cfg_x_lo = xl; cfg_x_hi = xh; cfg_y_lo = yl; cfg_y_hi = yh;
    cfg_x_res = xr; cfg_y_res = yr;
  endtask

  task automatic send(input bit rel, tap, clip, scale,
                      input logic [7:0] b0, b1, b2, b3);
    wait_idle();
    cfg_rel_mode = rel; cfg_tap_en = tap; cfg_clip_en = clip; cfg_scale_en = scale;
    pkt_data  = {b3, b2, b1, b0};
    pkt_valid = 1'b1;
    q.push_back(model(rel, tap, clip, scale, b0, b1, b2, b3));
    @(posedge clk);
    @(negedge clk);
    acc_cyc   = cyc;
    pkt_valid = 1'b0;
  endtask

  bit            prev_vld = 1'b0, prev_rdy = 1'b0;
  logic [CW-1:0] hx, hy;
  logic [5:0]    hz;
  logic          hb;

  always @(negedge clk) begin
    if (!rst) begin
      if (rpt_valid && prev_vld && !prev_rdy)
        check(rpt_x == hx && rpt_y == hy && rpt_z == hz && rpt_btn == hb,
              "R9", "held report changed", {rpt_x, rpt_y}, {hx, hy});
      if (rpt_valid && !prev_vld) begin
        check(!pkt_ready, "R8", "pkt_ready while report pending", pkt_ready, 0);
        if (ref_lat < 0) ref_lat = cyc - acc_cyc;
        else check(cyc - acc_cyc == ref_lat, "R8", "latency", cyc - acc_cyc, ref_lat);
      end
      rpt_ready = ($urandom % 4) != 0;
      if (rpt_valid && rpt_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "report with nothing expected", rpt_x, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rpt_x == e.x, "R1/R3/R5/R6", "rpt_x", rpt_x, e.x);
          check(rpt_y == e.y, "R1/R3/R5/R6", "rpt_y", rpt_y, e.y);
          check(rpt_z == e.z && rpt_btn == e.btn, "R2/R3", "z,btn",
                {rpt_z, rpt_btn}, {e.z, e.btn});
        end
      end
      prev_vld = rpt_valid;
      prev_rdy = rpt_ready;
      hx = rpt_x; hy = rpt_y; hz = rpt_z; hb = rpt_btn;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(pkt_ready == 1'b1 && rpt_valid == 1'b0, "R10", "reset outputs",
          {pkt_ready, rpt_valid}, 2'b10);
    // R1 R2: positive motion, tap on
    send(1, 1, 0, 0, 8'h01, 8'h05, 8'h07, 8'h00);
    // R1 R2: both negative, tap off hides button, byte 3 ignored
    send(1, 0, 1, 1, 8'h31, 8'hFB, 8'h80, 8'h3F);
    // R1: extreme -256 on X only
    send(1, 1, 0, 0, 8'h10, 8'h00, 8'h7F, 8'h00);
    // R3: nibble placement, Z masks bits 7:6
    send(0, 1, 0, 0, 8'h34, 8'h78, 8'hA5, 8'hFF);
    // R4: idle bypass with limiting and rescaling on
    send(0, 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h00);
    // R5: X below window, Y above window
    send(0, 0, 1, 0, 8'd50, 8'hFF, 8'hF0, 8'h01);
    // R5: inside window
    send(0, 0, 1, 0, 8'hE8, 8'h20, 8'h33, 8'h05);
    // R6: x=1000,y=800 -> 512,512
    send(0, 0, 1, 1, 8'hE8, 8'h20, 8'h33, 8'h05);
    // R7: scale without limiting leaves raw values
    send(0, 0, 0, 1, 8'hE8, 8'h20, 8'h33, 8'h05);
    // R4 R5 R6: only Z nonzero is not idle
    send(0, 0, 1, 0, 8'h00, 8'h00, 8'h00, 8'h01);
    send(0, 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h01);
    // R6: full-range window, full resolution
    set_win(16'd0, 16'd4095, 16'd1, 16'd2, 16'hFFFF, 16'hFFFF);
    send(0, 0, 1, 1, 8'hFF, 8'hFF, 8'hFF, 8'h02);
    send(0, 0, 1, 1, 8'h00, 8'h01, 8'h08, 8'h02);
    set_win(16'd100, 16'd1900, 16'd200, 16'd1400, 16'd640, 16'd480);
    // mixed random packets under random stalls
    for (int i = 0; i < 60; i++) begin
      int unsigned r;
      r = $urandom;
      send(r[0], r[1], r[2], r[3], 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    wait_idle();
    while (q.size() != 0 || rpt_valid) @(negedge clk);
    check(q.size() == 0, "R8", "reports outstanding", q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule